// File: doc/BRIEF.md
# TFT Timing Generator

This block produces the horizontal and vertical timing for a parallel RGB TFT panel. It has a set of control registers written through a simple write port. They hold the active width and height, the three blanking segments of each axis (front porch, sync pulse and back porch), a pixel-clock divisor, a video enable bit, sync polarity controls, a constant-colour override and a frame-sync interrupt. Each timing field is programmed as the wanted count minus one. The block walks a line through four segments in turn (active, front porch, sync, back porch) and walks a frame through the same four segments counted in lines.

Two identical segment sequencers are used, one per axis. Each has the named states `SEG_ACT`, `SEG_FP`, `SEG_SYNC` and `SEG_BP`. Every state exits to the next state in the list when the segment counter reaches the programmed length on a step; `SEG_BP` then wraps to `SEG_ACT`. The transitions are `ACT->FP` (end of active), `FP->SYNC` (sync entry), `SYNC->BP` (end of sync) and `BP->ACT` (wrap). Clearing video enable forces both sequencers back to `SEG_ACT` with a zero count. The horizontal sequencer steps on each pixel-clock enable. The vertical sequencer steps on the horizontal wrap.

Pixel data comes in on `pix_in` and is passed to `pix_out` inside the active region. When the override is enabled, the programmed colour is sent instead. Outside the active region `pix_out` is zero.

Top module: `tft_timing_gen`

## Requirements
- R1: The registers are at these word addresses: 0 control, 1 active width minus one in bits [10:0], 2 horizontal blanking, 3 active height minus one in bits [9:0], 4 vertical blanking, 5 override colour, 6 interrupt mask, 7 interrupt pending. In both blanking registers the front porch is in bits [7:0], the back porch in bits [15:8] and the sync width in bits [23:16], each stored as count minus one. Writes to addresses 1 to 4 are ignored while video is enabled and take effect when written while video is stopped.
- R2: The control register holds video enable in bit 0 and the divisor N in bits [10:1]. While video is enabled, `pix_ce` is high for one clock in every 2×(N+1) clocks. N=0 gives one pulse every 2 clocks.
- R3: Each line is, in pixel-clock ticks: active (width field+1), then front porch (field+1), then sync (field+1), then back porch (field+1). `hsync` is active only during the sync segment.
- R4: Each frame is, in lines: active (height field+1), then front porch, then sync, then back porch, each lasting its field+1. `vsync` is active only during the vertical sync segment.
- R5: `de` is high only when both axes are in their active segment. Inside that region `x_pos` and `y_pos` give the pixel and line index from 0. Outside it both are 0.
- R6: In the first clock after video enable is set, `de` is high with `x_pos`=0 and `y_pos`=0.
- R7: While video is disabled, `de` and `pix_ce` are low, both syncs are at their inactive level and `pix_out` is zero.
- R8: Both syncs are active-low by default. Control bit 11 inverts `hsync` and control bit 12 inverts `vsync`.
- R9: When override bit 24 of register 5 is set, `pix_out` shows the colour in bits [23:0] during `de`. When that bit is clear, `pix_out` shows `pix_in` during `de`.
- R10: `frm_pend` is set by the pixel tick that starts the vertical sync segment, so it is seen in the same clock as `vsync` goes active. Writing 1 to bit 0 of register 7 clears it, and writing 0 there has no effect.
- R11: `irq` is high exactly when `frm_pend` is set and mask bit 0 of register 6 is clear. The mask resets to 1 (masked).
- R12: After reset, all timing fields and the divisor are zero, video is disabled, `frm_pend` and `irq` are low, and both syncs are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| pix_in | input | 24 | Incoming pixel colour |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable, high in the active region |
| pix_ce | output | 1 | Pixel clock enable pulse |
| x_pos | output | 11 | Pixel index in the active line |
| y_pos | output | 10 | Line index in the active frame |
| pix_out | output | 24 | Outgoing pixel colour |
| frm_pend | output | 1 | Frame-sync pending flag |
| irq | output | 1 | Frame-sync interrupt request |

## Verification
A horizontal segment counter that is off by one shows up at once as an `hsync`, porch or `de` run that is 2×(N+1) clocks too long or too short. This appears in the first line after enable, and every line measured after that repeats the same error. A vertical sequencer error appears as a wrong `vsync` width, a wrong frame period or a wrong number of active lines within two frames. A pending-flag fault appears at the next vertical sync entry or at the next write to the pending register. A divider fault changes the spacing of `pix_ce` pulses within a few clocks.

// File: rtl/tft_tg_pkg.sv
package tft_tg_pkg;

    // Segment order is behavioural: active, front porch, sync, back porch
    typedef enum logic [1:0] {
        SEG_ACT  = 2'd0,
        SEG_FP   = 2'd1,
        SEG_SYNC = 2'd2,
        SEG_BP   = 2'd3
    } seg_e;

    localparam int REG_DW = 32;
    localparam int ADR_W  = 3;

    localparam logic [ADR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADR_W-1:0] ADR_HACT  = 3'd1;
    localparam logic [ADR_W-1:0] ADR_HBLK  = 3'd2;
    localparam logic [ADR_W-1:0] ADR_VACT  = 3'd3;
    localparam logic [ADR_W-1:0] ADR_VBLK  = 3'd4;
    localparam logic [ADR_W-1:0] ADR_TCOL  = 3'd5;
    localparam logic [ADR_W-1:0] ADR_MASK  = 3'd6;
    localparam logic [ADR_W-1:0] ADR_PEND  = 3'd7;

endpackage

// File: rtl/tft_pclk_div.sv
module tft_pclk_div #(
    parameter int DIVW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div_m1,
    output logic            pix_ce
);
    localparam int CNTW = DIVW + 1;

    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] last;
    logic            at_end;

    // period is 2*(N+1) clocks: count 0 .. 2N+1
    assign last   = {div_m1, 1'b1};
    assign at_end = (cnt >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pix_ce = run && at_end;

endmodule

// File: rtl/tft_seg_seq.sv
module tft_seg_seq
    import tft_tg_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [CW-1:0] len_act,
    input  logic [CW-1:0] len_fp,
    input  logic [CW-1:0] len_sync,
    input  logic [CW-1:0] len_bp,
    output seg_e          st,
    output logic [CW-1:0] cnt,
    output logic          seg_wrap,
    output logic          sync_enter
);
    seg_e          st_nx;
    logic [CW-1:0] cur_len;
    logic          seg_end;

    // next-state process
    always_comb begin
        unique case (st)
            SEG_ACT:  cur_len = len_act;
            SEG_FP:   cur_len = len_fp;
            SEG_SYNC: cur_len = len_sync;
            SEG_BP:   cur_len = len_bp;
        endcase
        seg_end = step && (cnt == cur_len);
        st_nx   = st;
        if (seg_end) begin
            unique case (st)
                SEG_ACT:  st_nx = SEG_FP;
                SEG_FP:   st_nx = SEG_SYNC;
                SEG_SYNC: st_nx = SEG_BP;
                SEG_BP:   st_nx = SEG_ACT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= SEG_ACT;
        end else if (!run) begin
            st <= SEG_ACT;
        end else begin
            st <= st_nx;
        end
    end

    // segment counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || seg_end) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign seg_wrap   = seg_end && (st == SEG_BP);
    assign sync_enter = seg_end && (st == SEG_FP);

endmodule

// File: rtl/tft_tg_regs.sv
module tft_tg_regs
    import tft_tg_pkg::*;
#(
    parameter int HW   = 11,
    parameter int VW   = 10,
    parameter int PW   = 8,
    parameter int DIVW = 10,
    parameter int COLW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADR_W-1:0]  wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic              pend_set,
    output logic              video_en,
    output logic [DIVW-1:0]   div_m1,
    output logic              hs_inv,
    output logic              vs_inv,
    output logic [HW-1:0]     hact_m1,
    output logic [PW-1:0]     hfp_m1,
    output logic [PW-1:0]     hbp_m1,
    output logic [PW-1:0]     hsw_m1,
    output logic [VW-1:0]     vact_m1,
    output logic [PW-1:0]     vfp_m1,
    output logic [PW-1:0]     vbp_m1,
    output logic [PW-1:0]     vsw_m1,
    output logic [COLW-1:0]   tc_color,
    output logic              tc_en,
    output logic              irq_mask,
    output logic              frm_pend
);
    localparam int HSI_BIT = DIVW + 1;
    localparam int VSI_BIT = DIVW + 2;

    logic ctl_wr, tim_wr, pend_clr;
    logic unused_bits;

    assign ctl_wr   = wr_en && (wr_addr == ADR_CTRL);
    assign tim_wr   = wr_en && !video_en;
    assign pend_clr = wr_en && (wr_addr == ADR_PEND) && wr_data[0];
    assign unused_bits = ^wr_data[REG_DW-1:COLW+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            video_en <= 1'b0;
            div_m1   <= '0;
            hs_inv   <= 1'b0;
            vs_inv   <= 1'b0;
        end else if (ctl_wr) begin
            video_en <= wr_data[0];
            div_m1   <= wr_data[DIVW:1];
            hs_inv   <= wr_data[HSI_BIT];
            vs_inv   <= wr_data[VSI_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hact_m1 <= '0;
            hfp_m1  <= '0;
            hbp_m1  <= '0;
            hsw_m1  <= '0;
            vact_m1 <= '0;
            vfp_m1  <= '0;
            vbp_m1  <= '0;
            vsw_m1  <= '0;
        end else if (tim_wr) begin
            unique case (wr_addr)
                ADR_HACT: hact_m1 <= wr_data[HW-1:0];
                ADR_HBLK: begin
                    hfp_m1 <= wr_data[PW-1:0];
                    hbp_m1 <= wr_data[2*PW-1:PW];
                    hsw_m1 <= wr_data[3*PW-1:2*PW];
                end
                ADR_VACT: vact_m1 <= wr_data[VW-1:0];
                ADR_VBLK: begin
                    vfp_m1 <= wr_data[PW-1:0];
                    vbp_m1 <= wr_data[2*PW-1:PW];
                    vsw_m1 <= wr_data[3*PW-1:2*PW];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_color <= '0;
            tc_en    <= 1'b0;
            irq_mask <= 1'b1;
        end else if (wr_en) begin
            if (wr_addr == ADR_TCOL) begin
                tc_color <= wr_data[COLW-1:0];
                tc_en    <= wr_data[COLW];
            end
            if (wr_addr == ADR_MASK) begin
                irq_mask <= wr_data[0];
            end
        end
    end

    // a new frame event outranks a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_pend <= 1'b0;
        end else if (pend_set) begin
            frm_pend <= 1'b1;
        end else if (pend_clr) begin
            frm_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
    import tft_tg_pkg::*;
#(
    parameter int HW   = 11,
    parameter int VW   = 10,
    parameter int PW   = 8,
    parameter int DIVW = 10,
    parameter int COLW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADR_W-1:0]  wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [COLW-1:0]   pix_in,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              pix_ce,
    output logic [HW-1:0]     x_pos,
    output logic [VW-1:0]     y_pos,
    output logic [COLW-1:0]   pix_out,
    output logic              frm_pend,
    output logic              irq
);
    localparam int HCW = (HW > PW) ? HW : PW;
    localparam int VCW = (VW > PW) ? VW : PW;

    logic            ctl_en, ctl_hs_inv, ctl_vs_inv;
    logic [DIVW-1:0] div_m1;
    logic [HW-1:0]   hact_m1;
    logic [VW-1:0]   vact_m1;
    logic [PW-1:0]   hfp_m1, hbp_m1, hsw_m1, vfp_m1, vbp_m1, vsw_m1;
    logic [COLW-1:0] tc_color;
    logic            tc_en, irq_mask;

    seg_e            h_st, v_st;
    logic [HCW-1:0]  h_cnt;
    logic [VCW-1:0]  v_cnt;
    logic            h_wrap, h_sync_enter_unused;
    logic            v_wrap_unused, v_sync_enter;
    logic            h_sync_act, v_sync_act, in_active;

    tft_tg_regs #(
        .HW(HW), .VW(VW), .PW(PW), .DIVW(DIVW), .COLW(COLW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pend_set (v_sync_enter),
        .video_en (ctl_en),
        .div_m1   (div_m1),
        .hs_inv   (ctl_hs_inv),
        .vs_inv   (ctl_vs_inv),
        .hact_m1  (hact_m1),
        .hfp_m1   (hfp_m1),
        .hbp_m1   (hbp_m1),
        .hsw_m1   (hsw_m1),
        .vact_m1  (vact_m1),
        .vfp_m1   (vfp_m1),
        .vbp_m1   (vbp_m1),
        .vsw_m1   (vsw_m1),
        .tc_color (tc_color),
        .tc_en    (tc_en),
        .irq_mask (irq_mask),
        .frm_pend (frm_pend)
    );

    tft_pclk_div #(.DIVW(DIVW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctl_en),
        .div_m1 (div_m1),
        .pix_ce (pix_ce)
    );

    tft_seg_seq #(.CW(HCW)) u_hseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctl_en),
        .step       (pix_ce),
        .len_act    (HCW'(hact_m1)),
        .len_fp     (HCW'(hfp_m1)),
        .len_sync   (HCW'(hsw_m1)),
        .len_bp     (HCW'(hbp_m1)),
        .st         (h_st),
        .cnt        (h_cnt),
        .seg_wrap   (h_wrap),
        .sync_enter (h_sync_enter_unused)
    );

    tft_seg_seq #(.CW(VCW)) u_vseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctl_en),
        .step       (h_wrap),
        .len_act    (VCW'(vact_m1)),
        .len_fp     (VCW'(vfp_m1)),
        .len_sync   (VCW'(vsw_m1)),
        .len_bp     (VCW'(vbp_m1)),
        .st         (v_st),
        .cnt        (v_cnt),
        .seg_wrap   (v_wrap_unused),
        .sync_enter (v_sync_enter)
    );

    // output process
    always_comb begin
        h_sync_act = ctl_en && (h_st == SEG_SYNC);
        v_sync_act = ctl_en && (v_st == SEG_SYNC);
        in_active  = ctl_en && (h_st == SEG_ACT) && (v_st == SEG_ACT);

        hsync = h_sync_act ? ctl_hs_inv : ~ctl_hs_inv;
        vsync = v_sync_act ? ctl_vs_inv : ~ctl_vs_inv;
        de    = in_active;

        if (in_active) begin
            x_pos   = h_cnt[HW-1:0];
            y_pos   = v_cnt[VW-1:0];
            pix_out = tc_en ? tc_color : pix_in;
        end else begin
            x_pos   = '0;
            y_pos   = '0;
            pix_out = '0;
        end

        irq = frm_pend && !irq_mask;
    end

endmodule

// File: rtl/tft_timing_chk.sv
module tft_timing_chk #(
    parameter int HW = 11,
    parameter int VW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          wr_en,
    input logic          pix_ce,
    input logic          de,
    input logic          hsync,
    input logic          hs_inv,
    input logic [HW-1:0] x_pos,
    input logic [VW-1:0] y_pos,
    input logic [HW-1:0] hact_m1,
    input logic          v_sync_act,
    input logic          frm_pend
);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!pix_ce && !de));

    // R2
    ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |=> !pix_ce);

    // R5
    x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr_en && pix_ce && de && (x_pos != hact_m1))
        |=> (de && (x_pos == $past(x_pos) + 1'b1)));

    // R5
    x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr_en && !pix_ce) |=> $stable(x_pos));

    // R3
    de_hsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync != hs_inv));

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (de && (x_pos == '0) && (y_pos == '0)));

    // R10
    pend_on_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_sync_act) |-> frm_pend);

endmodule

bind tft_timing_gen tft_timing_chk #(.HW(HW), .VW(VW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ctl_en),
    .wr_en      (wr_en),
    .pix_ce     (pix_ce),
    .de         (de),
    .hsync      (hsync),
    .hs_inv     (ctl_hs_inv),
    .x_pos      (x_pos),
    .y_pos      (y_pos),
    .hact_m1    (hact_m1),
    .v_sync_act (v_sync_act),
    .frm_pend   (frm_pend)
);

// File: tb/tft_timing_gen_tb.sv
`timescale 1ns/1ps
module tft_timing_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [23:0] pix_in = '0;
    logic        hsync, vsync, de, pix_ce, frm_pend, irq;
    logic [10:0] x_pos;
    logic [9:0]  y_pos;
    logic [23:0] pix_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    // current configuration, all fields as count minus one
    int c_ha, c_hf, c_hb, c_hs, c_va, c_vf, c_vb, c_vs, c_dv, c_hi, c_vi;

    always #2.5 clk = ~clk;

    tft_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_in(pix_in), .hsync(hsync), .vsync(vsync),
        .de(de), .pix_ce(pix_ce), .x_pos(x_pos), .y_pos(y_pos),
        .pix_out(pix_out), .frm_pend(frm_pend), .irq(irq)
    );

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(input int en, input int dv, input int hi, input int vi);
        return (32'(en) & 32'h1) | (32'(dv) << 1) | (32'(hi) << 11) | (32'(vi) << 12);
    endfunction

    function automatic logic [31:0] blk_word(input int fp, input int bp, input int sw);
        return 32'(fp) | (32'(bp) << 8) | (32'(sw) << 16);
    endfunction

    task automatic prog(input int ha, input int hf, input int hb, input int hs,
                        input int va, input int vf, input int vb, input int vs,
                        input int dv, input int hi, input int vi);
        c_ha = ha; c_hf = hf; c_hb = hb; c_hs = hs;
        c_va = va; c_vf = vf; c_vb = vb; c_vs = vs;
        c_dv = dv; c_hi = hi; c_vi = vi;
        wr(3'd0, ctrl_word(0, dv, hi, vi));
        wr(3'd1, 32'(ha));
        wr(3'd2, blk_word(hf, hb, hs));
        wr(3'd3, 32'(va));
        wr(3'd4, blk_word(vf, vb, vs));
        wr(3'd7, 32'h1);
        wr(3'd0, ctrl_word(1, dv, hi, vi));
        @(negedge clk);
        // R6: first clock after enable sits on pixel 0 of line 0
        chk(de && x_pos == 0 && y_pos == 0, "R6 restart at first pixel", {de, x_pos, y_pos}, {1'b1, 21'd0});
    endtask

    task automatic measure(input string tag);
        int d, l, f, lim;
        int hr = -1, hf = -1, dr = -1, dfl = -1, vr = -1, cl = -1;
        int e_ce = 0, e_hw = 0, e_ln = 0, e_hfp = 0, e_hbp = 0, e_de = 0;
        int e_vw = 0, e_fr = 0, e_nl = 0, e_pd = 0, e_xy = 0;
        int nvs = 0, nl = 0;
        bit hp = 0, vp = 0, dp = 0;
        d   = 2 * (c_dv + 1);
        l   = (c_ha + c_hf + c_hb + c_hs + 4) * d;
        f   = (c_va + c_vf + c_vb + c_vs + 4) * l;
        lim = 2 * f + 2 * l;
        for (int t = 0; t < lim; t++) begin
            bit ha, va, da;
            @(negedge clk);
            ha = (hsync == c_hi[0]);
            va = (vsync == c_vi[0]);
            da = de;
            if (t > 0) begin
                if (pix_ce) begin
                    if (cl >= 0 && t - cl != d) e_ce++;
                    cl = t;
                end
                if (ha && !hp) begin
                    if (hr >= 0 && t - hr != l) e_ln++;
                    if (dfl >= 0 && t - dfl != (c_hf + 1) * d) e_hfp++;
                    dfl = -1;
                    hr = t;
                end
                if (!ha && hp) begin
                    if (hr >= 0 && t - hr != (c_hs + 1) * d) e_hw++;
                    hf = t;
                end
                if (da && !dp) begin
                    if (hf >= 0 && t - hf != (c_hb + 1) * d) e_hbp++;
                    dr = t;
                    nl++;
                    if (x_pos != 0 || (vr >= 0 && int'(y_pos) != nl - 1)) e_xy++;
                end
                if (!da && dp) begin
                    if (dr >= 0 && t - dr != (c_ha + 1) * d) e_de++;
                    dfl = t;
                end
                if (da && int'(x_pos) > c_ha) e_xy++;
                if (!da && (x_pos != 0 || y_pos != 0 || pix_out != 0)) e_xy++;
                if (va && !vp) begin
                    if (vr >= 0) begin
                        if (t - vr != f) e_fr++;
                        if (nl != c_va + 1) e_nl++;
                    end
                    if (!frm_pend) e_pd++;
                    nl = 0;
                    nvs++;
                    vr = t;
                end
                if (!va && vp) begin
                    if (vr >= 0 && t - vr != (c_vs + 1) * l) e_vw++;
                end
            end
            hp = ha; vp = va; dp = da;
        end
        chk(e_ce == 0,  {tag, " R2 pix_ce spacing"}, e_ce, 0);
        chk(e_hw == 0,  {tag, " R3 hsync width"}, e_hw, 0);
        chk(e_ln == 0,  {tag, " R3 line period"}, e_ln, 0);
        chk(e_hfp == 0, {tag, " R3 horizontal front porch"}, e_hfp, 0);
        chk(e_hbp == 0, {tag, " R3 horizontal back porch"}, e_hbp, 0);
        chk(e_de == 0,  {tag, " R3 active width"}, e_de, 0);
        chk(e_vw == 0,  {tag, " R4 vsync width"}, e_vw, 0);
        chk(e_fr == 0,  {tag, " R4 frame period"}, e_fr, 0);
        chk(e_nl == 0,  {tag, " R4 active lines per frame"}, e_nl, 0);
        chk(nvs >= 2,   {tag, " R4 vsync pulses seen"}, nvs, 2);
        chk(e_xy == 0,  {tag, " R5 coordinates and blanking"}, e_xy, 0);
        chk(e_pd == 0,  {tag, " R10 pending at vsync entry"}, e_pd, 0);
    endtask

    task automatic wait_de(input bit lvl);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (de == lvl) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int bad;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!de && !pix_ce && hsync && vsync, "R12 reset outputs", {de, pix_ce, hsync, vsync}, 4'b0011);
        chk(!frm_pend && !irq && pix_out == 0, "R12 reset interrupt", {frm_pend, irq}, 0);

        // minimum settings: every field zero, fastest divisor (R2, R3, R4)
        prog(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        measure("min");

        // directed wider setting with both syncs inverted (R8)
        prog(9, 2, 3, 1, 3, 1, 2, 0, 1, 1, 1);
        measure("inv");

        // random settings
        for (int k = 0; k < 6; k++) begin
            prog(1 + $urandom_range(10), $urandom_range(4), $urandom_range(4), $urandom_range(4),
                 $urandom_range(5), $urandom_range(4), $urandom_range(4), $urandom_range(4),
                 $urandom_range(2), $urandom_range(1), $urandom_range(1));
            measure("rnd");
        end

        // R1: timing writes while enabled are ignored
        prog(5, 1, 1, 1, 2, 0, 1, 0, 0, 0, 0);
        wr(3'd1, 32'd12);
        wr(3'd2, blk_word(7, 7, 7));
        measure("R1 ignored");

        // R7: disabled output state
        wr(3'd0, ctrl_word(0, 0, 0, 0));
        bad = 0;
        pix_in = 24'hFFFFFF;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (de || pix_ce || !hsync || !vsync || pix_out != 0) bad++;
        end
        chk(bad == 0, "R7 quiet while disabled", bad, 0);

        // R1: timing writes while stopped take effect
        prog(12, 0, 2, 1, 1, 1, 0, 1, 0, 0, 0);
        measure("R1 applied");

        // R9: colour override
        pix_in = 24'h5A3C81;
        wr(3'd5, 32'h0100_0000 | 32'h123456);
        wait_de(1'b1);
        chk(pix_out == 24'h123456, "R9 override colour", pix_out, 24'h123456);
        wait_de(1'b0);
        chk(pix_out == 0, "R9 zero outside active", pix_out, 0);
        wr(3'd5, 32'h123456);
        wait_de(1'b1);
        chk(pix_out == 24'h5A3C81, "R9 pass-through", pix_out, 24'h5A3C81);

        // R10 / R11: pending and mask
        wr(3'd7, 32'h1);
        @(negedge clk);
        chk(!frm_pend, "R10 clear by writing one", frm_pend, 0);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (frm_pend) break;
        end
        chk(frm_pend && vsync == 1'b0, "R10 set with vsync entry", {frm_pend, vsync}, 2'b10);
        chk(!irq, "R11 masked after reset", irq, 0);
        wr(3'd6, 32'h0);
        @(negedge clk);
        chk(irq, "R11 irq when unmasked", irq, 1);
        wr(3'd7, 32'h0);
        @(negedge clk);
        chk(frm_pend, "R10 writing zero has no effect", frm_pend, 1);
        wr(3'd7, 32'h1);
        @(negedge clk);
        chk(!frm_pend && !irq, "R11 irq drops after clear", {frm_pend, irq}, 0);
        wr(3'd6, 32'h1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule